// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Address-Space Tags

This block caches page translations in a small fully associative array. Every entry carries a virtual page tag, a physical page number, an address-space number, a global bit that makes the entry visible to every address space, read-enable and write-enable masks with one bit per privilege mode, and fault-on-read and fault-on-write flags. A lookup compares the requested page and the current address-space number against all entries at once, in the same cycle. The matching entry's physical page, masks and fault flags come out unchanged. The permission and translation logic that consumes them sits outside this block.

Software-style maintenance is driven through single-cycle commands. An insert places a new entry at a round-robin victim pointer. Three commands remove entries: one clears the whole array, one drops entries for a single page in one address space, and one drops every entry that is not global. A peek port shows the entry under the victim pointer, and an advance input moves the pointer on without writing anything. Pages are 8 KiB, so every page number is the virtual address from bit 13 upward. The depth is a parameter. It is 48 for an instruction-side instance and 64 for a data-side instance.

Top module: `tlb_asn_cam`

## Requirements
- R1: In the same cycle as the request, a lookup reports a hit only for a valid entry whose tag equals `lk_vpn` and which is either global or holds an address-space number equal to `lk_asn`. On a hit, the entry's physical page, masks and fault flags appear on the lookup outputs. On a miss, those outputs are zero.
- R2: When more than one entry matches a lookup, the outputs come from the entry with the lowest index.
- R3: An insert writes the entry at the victim pointer, overwriting whatever is there. It takes the tag from address bits 13 and up (`ins_va`), sets the entry valid, and advances the pointer by one. A flush command in the same cycle as an insert is not permitted.
- R4: The victim pointer steps through indices 0, 1, and on up to DEPTH-1, then wraps to 0.
- R5: Flush-all leaves every entry invalid from the next cycle on.
- R6: Flush-by-address invalidates each valid entry whose tag equals `fa_va` (address bits 13 and up) and which is either global or holds an address-space number equal to `fa_asn`. All other entries are left as they were.
- R7: Flush-non-global invalidates every entry whose global bit is clear and keeps every global entry.
- R8: The peek outputs always show the entry at the victim pointer. The pointer advances when `pk_adv` or `ins_en` is high and holds otherwise. When both are high in the same cycle, it advances by exactly one.
- R9: After reset, every entry is invalid and the victim pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Current address-space number |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_ppn | output | PPN_W | Physical page of the matching entry |
| lk_rd_mask | output | MODES | Read-enable mask, one bit per mode |
| lk_wr_mask | output | MODES | Write-enable mask, one bit per mode |
| lk_fault_rd | output | 1 | Fault-on-read flag |
| lk_fault_wr | output | 1 | Fault-on-write flag |
| ins_en | input | 1 | Insert strobe |
| ins_va | input | VPN_W | Virtual address bits 13 and up for the new entry |
| ins_ppn | input | PPN_W | New physical page |
| ins_asn | input | ASN_W | New address-space number |
| ins_global | input | 1 | New entry is global |
| ins_rd_mask | input | MODES | New read-enable mask |
| ins_wr_mask | input | MODES | New write-enable mask |
| ins_fault_rd | input | 1 | New fault-on-read flag |
| ins_fault_wr | input | 1 | New fault-on-write flag |
| fl_all | input | 1 | Flush every entry |
| fa_en | input | 1 | Flush-by-address strobe |
| fa_va | input | VPN_W | Address bits 13 and up to flush |
| fa_asn | input | ASN_W | Address-space number for flush-by-address |
| fng_en | input | 1 | Flush every non-global entry |
| pk_adv | input | 1 | Advance the victim pointer without writing |
| pk_valid | output | 1 | Valid bit of the entry at the pointer |
| pk_vpn | output | VPN_W | Tag of the entry at the pointer |
| pk_ppn | output | PPN_W | Physical page of the entry at the pointer |
| pk_asn | output | ASN_W | Address-space number of the entry at the pointer |
| pk_global | output | 1 | Global bit of the entry at the pointer |

## Verification
The assertions watch several properties on every cycle. They check that the pointer steps and wraps correctly and holds when idle. They check that an insert lands at the old pointer with the right tag, and that the array is empty after a flush-all. They check that no non-global entry survives a flush-non-global, that a reported hit has no lower-index competitor, and that inserts and flushes never collide. Other behaviour can only be shown by the bench scenarios. Those include address-space matching against the global bit, selective survival under flush-by-address with a mismatched number, overwriting of an old entry after the pointer wraps, and peeking at the pointer without moving it.

// File: rtl/tlb_asn_pkg.sv
package tlb_asn_pkg;
  parameter int VA_W     = 43;
  parameter int PG_SHIFT = 13;
  parameter int PPN_W    = 28;
  parameter int ASN_W    = 8;
  parameter int MODES    = 4;
  localparam int VPN_W   = VA_W - PG_SHIFT;

  typedef struct packed {
    logic             valid;
    logic [VPN_W-1:0] tag;
    logic [PPN_W-1:0] ppn;
    logic [ASN_W-1:0] asn;
    logic             glob;
    logic [MODES-1:0] rd_mask;
    logic [MODES-1:0] wr_mask;
    logic             fault_rd;
    logic             fault_wr;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match
  import tlb_asn_pkg::*;
#(
  parameter int DEPTH = 48
) (
  input  tlb_entry_t [DEPTH-1:0] ents,
  input  logic [VPN_W-1:0]       vpn,
  input  logic [ASN_W-1:0]       asn,
  output logic [DEPTH-1:0]       match
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = ents[g].valid && (ents[g].tag == vpn) &&
                      (ents[g].glob || (ents[g].asn == asn));
  end
endmodule

// File: rtl/tlb_first_sel.sv
module tlb_first_sel #(
  parameter int DEPTH = 48,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    found = |req;
  end
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int DEPTH = 48,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (step) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_q <= '0;
    else if (step) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + IDX_W'(1)));

  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ptr_q));
endmodule

// File: rtl/tlb_asn_cam.sv
module tlb_asn_cam
  import tlb_asn_pkg::*;
#(
  parameter int DEPTH = 48
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [VPN_W-1:0]          lk_vpn,
  input  logic [ASN_W-1:0]          lk_asn,
  output logic                      lk_hit,
  output logic [PPN_W-1:0]          lk_ppn,
  output logic [MODES-1:0]          lk_rd_mask,
  output logic [MODES-1:0]          lk_wr_mask,
  output logic                      lk_fault_rd,
  output logic                      lk_fault_wr,
  input  logic                      ins_en,
  input  logic [VA_W-1:PG_SHIFT]    ins_va,
  input  logic [PPN_W-1:0]          ins_ppn,
  input  logic [ASN_W-1:0]          ins_asn,
  input  logic                      ins_global,
  input  logic [MODES-1:0]          ins_rd_mask,
  input  logic [MODES-1:0]          ins_wr_mask,
  input  logic                      ins_fault_rd,
  input  logic                      ins_fault_wr,
  input  logic                      fl_all,
  input  logic                      fa_en,
  input  logic [VA_W-1:PG_SHIFT]    fa_va,
  input  logic [ASN_W-1:0]          fa_asn,
  input  logic                      fng_en,
  input  logic                      pk_adv,
  output logic                      pk_valid,
  output logic [VPN_W-1:0]          pk_vpn,
  output logic [PPN_W-1:0]          pk_ppn,
  output logic [ASN_W-1:0]          pk_asn,
  output logic                      pk_global
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  tlb_entry_t [DEPTH-1:0] ent_q, ent_d;
  logic [DEPTH-1:0]       hit_vec, fa_vec, valid_vec, glob_vec;
  logic [IDX_W-1:0]       lk_idx, wr_ptr;
  logic                   ent_we;
  tlb_entry_t             new_ent;

  tlb_tag_match #(.DEPTH(DEPTH)) u_lk_match (
    .ents(ent_q), .vpn(lk_vpn), .asn(lk_asn), .match(hit_vec));

  tlb_tag_match #(.DEPTH(DEPTH)) u_fa_match (
    .ents(ent_q), .vpn(fa_va), .asn(fa_asn), .match(fa_vec));

  tlb_first_sel #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_first (
    .req(hit_vec), .found(lk_hit), .idx(lk_idx));

  tlb_rr_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(srst_n), .step(ins_en | pk_adv), .ptr(wr_ptr));

  for (genvar g = 0; g < DEPTH; g++) begin : g_flags
    assign valid_vec[g] = ent_q[g].valid;
    assign glob_vec[g]  = ent_q[g].glob;
  end

  always_comb begin
    new_ent          = '0;
    new_ent.valid    = 1'b1;
    new_ent.tag      = ins_va;
    new_ent.ppn      = ins_ppn;
    new_ent.asn      = ins_asn;
    new_ent.glob     = ins_global;
    new_ent.rd_mask  = ins_rd_mask;
    new_ent.wr_mask  = ins_wr_mask;
    new_ent.fault_rd = ins_fault_rd;
    new_ent.fault_wr = ins_fault_wr;
  end

  // next-state of the entry array
  always_comb begin
    ent_d = ent_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (fl_all) begin
        ent_d[i] = '0;
      end else begin
        if (fa_en && fa_vec[i])                   ent_d[i].valid = 1'b0;
        if (fng_en && valid_vec[i] && !glob_vec[i]) ent_d[i].valid = 1'b0;
      end
    end
    if (ins_en) ent_d[wr_ptr] = new_ent;
  end

  assign ent_we = ins_en | fl_all | fa_en | fng_en;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     ent_q <= '0;
    else if (ent_we) ent_q <= ent_d;
  end

  // lookup outputs, zero on a miss
  assign lk_ppn      = ent_q[lk_idx].ppn     & {PPN_W{lk_hit}};
  assign lk_rd_mask  = ent_q[lk_idx].rd_mask & {MODES{lk_hit}};
  assign lk_wr_mask  = ent_q[lk_idx].wr_mask & {MODES{lk_hit}};
  assign lk_fault_rd = ent_q[lk_idx].fault_rd & lk_hit;
  assign lk_fault_wr = ent_q[lk_idx].fault_wr & lk_hit;

  // peek at the victim slot
  assign pk_valid  = ent_q[wr_ptr].valid;
  assign pk_vpn    = ent_q[wr_ptr].tag;
  assign pk_ppn    = ent_q[wr_ptr].ppn;
  assign pk_asn    = ent_q[wr_ptr].asn;
  assign pk_global = ent_q[wr_ptr].glob;

  logic [DEPTH-1:0] below_mask;
  assign below_mask = (DEPTH'(1) << lk_idx) - DEPTH'(1);

  p_lowest_wins_r2: assert property (@(posedge clk) disable iff (!srst_n)
    lk_hit |-> (hit_vec[lk_idx] && ((hit_vec & below_mask) == '0)));

  p_no_flush_with_ins_r3: assert property (@(posedge clk) disable iff (!srst_n)
    ins_en |-> !(fl_all || fa_en || fng_en));

  p_ins_lands_r3: assert property (@(posedge clk) disable iff (!srst_n)
    ins_en |=> ent_q[$past(wr_ptr)].valid && (ent_q[$past(wr_ptr)].tag == $past(ins_va)));

  p_flush_all_empty_r5: assert property (@(posedge clk) disable iff (!srst_n)
    fl_all |=> valid_vec == '0);

  p_flush_ng_keeps_global_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (fng_en && !ins_en) |=> (valid_vec & ~glob_vec) == '0);
endmodule

// File: tb/tlb_asn_cam_tb.sv
module tlb_asn_cam_tb;
  import tlb_asn_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [VPN_W-1:0] lk_vpn;
  logic [ASN_W-1:0] lk_asn;
  logic lk_hit, lk_fault_rd, lk_fault_wr;
  logic [PPN_W-1:0] lk_ppn;
  logic [MODES-1:0] lk_rd_mask, lk_wr_mask;
  logic ins_en, ins_global, ins_fault_rd, ins_fault_wr;
  logic [VPN_W-1:0] ins_va, fa_va;
  logic [PPN_W-1:0] ins_ppn;
  logic [ASN_W-1:0] ins_asn, fa_asn;
  logic [MODES-1:0] ins_rd_mask, ins_wr_mask;
  logic fl_all, fa_en, fng_en, pk_adv;
  logic pk_valid, pk_global;
  logic [VPN_W-1:0] pk_vpn;
  logic [PPN_W-1:0] pk_ppn;
  logic [ASN_W-1:0] pk_asn;

  tlb_asn_cam #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .lk_rd_mask(lk_rd_mask), .lk_wr_mask(lk_wr_mask),
    .lk_fault_rd(lk_fault_rd), .lk_fault_wr(lk_fault_wr),
    .ins_en(ins_en), .ins_va(ins_va), .ins_ppn(ins_ppn), .ins_asn(ins_asn),
    .ins_global(ins_global), .ins_rd_mask(ins_rd_mask), .ins_wr_mask(ins_wr_mask),
    .ins_fault_rd(ins_fault_rd), .ins_fault_wr(ins_fault_wr),
    .fl_all(fl_all), .fa_en(fa_en), .fa_va(fa_va), .fa_asn(fa_asn), .fng_en(fng_en),
    .pk_adv(pk_adv), .pk_valid(pk_valid), .pk_vpn(pk_vpn), .pk_ppn(pk_ppn),
    .pk_asn(pk_asn), .pk_global(pk_global));

  // reference model of the array
  logic             m_v   [DEPTH];
  logic [VPN_W-1:0] m_tag [DEPTH];
  logic [PPN_W-1:0] m_ppn [DEPTH];
  logic [ASN_W-1:0] m_asn [DEPTH];
  logic             m_g   [DEPTH];
  logic [MODES-1:0] m_rd  [DEPTH];
  logic [MODES-1:0] m_wr  [DEPTH];
  logic             m_fr  [DEPTH];
  logic             m_fw  [DEPTH];
  int               m_ptr;

  typedef struct {
    bit               is_pk;
    string            req;
    logic             hit;
    logic [PPN_W-1:0] ppn;
    logic [MODES-1:0] rd;
    logic [MODES-1:0] wr;
    logic             fr;
    logic             fw;
    logic [VPN_W-1:0] vpn;
    logic [ASN_W-1:0] asn;
    logic             g;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // monitor: compare against the queued expectation
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (!it.is_pk) begin
        if (lk_hit !== it.hit ||
            (it.hit && (lk_ppn !== it.ppn || lk_rd_mask !== it.rd || lk_wr_mask !== it.wr ||
                        lk_fault_rd !== it.fr || lk_fault_wr !== it.fw)) ||
            (!it.hit && lk_ppn !== '0)) begin
          failures++;
          $display("FAIL %s lookup: hit=%0b ppn=%h rd=%h wr=%h fr=%0b fw=%0b expected hit=%0b ppn=%h rd=%h wr=%h fr=%0b fw=%0b",
                   it.req, lk_hit, lk_ppn, lk_rd_mask, lk_wr_mask, lk_fault_rd, lk_fault_wr,
                   it.hit, it.ppn, it.rd, it.wr, it.fr, it.fw);
        end
      end else begin
        if (pk_valid !== it.hit ||
            (it.hit && (pk_vpn !== it.vpn || pk_ppn !== it.ppn || pk_asn !== it.asn || pk_global !== it.g))) begin
          failures++;
          $display("FAIL %s peek: valid=%0b vpn=%h ppn=%h asn=%h g=%0b expected valid=%0b vpn=%h ppn=%h asn=%h g=%0b",
                   it.req, pk_valid, pk_vpn, pk_ppn, pk_asn, pk_global,
                   it.hit, it.vpn, it.ppn, it.asn, it.g);
        end
      end
    end
  end

  task automatic idle();
    ins_en = 0; fl_all = 0; fa_en = 0; fng_en = 0; pk_adv = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_insert(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                           input logic [ASN_W-1:0] asn, input logic g,
                           input logic [MODES-1:0] rd, input logic [MODES-1:0] wr,
                           input logic fr, input logic fw);
    ins_en = 1; ins_va = vpn; ins_ppn = ppn; ins_asn = asn; ins_global = g;
    ins_rd_mask = rd; ins_wr_mask = wr; ins_fault_rd = fr; ins_fault_wr = fw;
    step();
    m_v[m_ptr] = 1; m_tag[m_ptr] = vpn; m_ppn[m_ptr] = ppn; m_asn[m_ptr] = asn;
    m_g[m_ptr] = g; m_rd[m_ptr] = rd; m_wr[m_ptr] = wr; m_fr[m_ptr] = fr; m_fw[m_ptr] = fw;
    m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
  endtask

  task automatic check_lookup(input string req, input logic [VPN_W-1:0] vpn,
                              input logic [ASN_W-1:0] asn);
    item_t it;
    lk_vpn = vpn; lk_asn = asn;
    it = '{is_pk: 0, req: req, hit: 0, ppn: '0, rd: '0, wr: '0, fr: 0, fw: 0,
           vpn: '0, asn: '0, g: 0};
    for (int i = 0; i < DEPTH; i++) begin
      if (!it.hit && m_v[i] && m_tag[i] == vpn && (m_g[i] || m_asn[i] == asn)) begin
        it.hit = 1; it.ppn = m_ppn[i]; it.rd = m_rd[i]; it.wr = m_wr[i];
        it.fr = m_fr[i]; it.fw = m_fw[i];
      end
    end
    sb.push_back(it);
    step();
  endtask

  task automatic check_peek(input string req, input logic adv);
    item_t it;
    it = '{is_pk: 1, req: req, hit: m_v[m_ptr], ppn: m_ppn[m_ptr], rd: '0, wr: '0,
           fr: 0, fw: 0, vpn: m_tag[m_ptr], asn: m_asn[m_ptr], g: m_g[m_ptr]};
    pk_adv = adv;
    sb.push_back(it);
    step();
    if (adv) m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
  endtask

  task automatic flush_addr(input logic [VPN_W-1:0] vpn, input logic [ASN_W-1:0] asn);
    fa_en = 1; fa_va = vpn; fa_asn = asn;
    step();
    for (int i = 0; i < DEPTH; i++)
      if (m_v[i] && m_tag[i] == vpn && (m_g[i] || m_asn[i] == asn)) m_v[i] = 0;
  endtask

  task automatic flush_ng();
    fng_en = 1;
    step();
    for (int i = 0; i < DEPTH; i++) if (!m_g[i]) m_v[i] = 0;
  endtask

  task automatic flush_everything();
    fl_all = 1;
    step();
    for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    idle();
    lk_vpn = '0; lk_asn = '0; ins_va = '0; ins_ppn = '0; ins_asn = '0; ins_global = 0;
    ins_rd_mask = '0; ins_wr_mask = '0; ins_fault_rd = 0; ins_fault_wr = 0;
    fa_va = '0; fa_asn = '0;
    m_ptr = 0;
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i] = 0; m_tag[i] = '0; m_ppn[i] = '0; m_asn[i] = '0; m_g[i] = 0;
      m_rd[i] = '0; m_wr[i] = '0; m_fr[i] = 0; m_fw[i] = 0;
    end
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;

    // R9: empty after reset, pointer at 0
    check_peek("R9", 0);
    check_lookup("R9", '0, '0);

    // R1: address-space matching against the global bit
    do_insert(30'h10, 28'h100, 8'h01, 0, 4'h3, 4'h1, 0, 1);
    check_lookup("R1", 30'h10, 8'h01);
    check_lookup("R1", 30'h10, 8'h02);
    check_lookup("R1", 30'h11, 8'h01);
    do_insert(30'h20, 28'h200, 8'h03, 1, 4'hF, 4'h0, 1, 0);
    check_lookup("R1", 30'h20, 8'h77);

    // R2: duplicate tag in a higher slot; lowest index wins
    do_insert(30'h10, 28'h300, 8'h01, 0, 4'h5, 4'h5, 0, 0);
    check_lookup("R2", 30'h10, 8'h01);

    // R8: peek without advance, then advance, then peek again
    check_peek("R8", 0);
    check_peek("R8", 0);
    check_peek("R8", 1);
    do_insert(30'h30, 28'h400, 8'h05, 0, 4'h1, 4'h1, 0, 0);
    check_lookup("R8", 30'h30, 8'h05);

    // R6: matching flush removes both copies, global entry survives
    flush_addr(30'h10, 8'h01);
    check_lookup("R6", 30'h10, 8'h01);
    check_lookup("R6", 30'h20, 8'h03);
    flush_addr(30'h30, 8'h06);
    check_lookup("R6", 30'h30, 8'h05);
    flush_addr(30'h20, 8'h44);
    check_lookup("R6", 30'h20, 8'h03);

    // R7: non-global flush
    do_insert(30'h40, 28'h500, 8'h09, 1, 4'h2, 4'h2, 0, 0);
    do_insert(30'h50, 28'h600, 8'h09, 0, 4'h2, 4'h2, 0, 0);
    flush_ng();
    check_lookup("R7", 30'h50, 8'h09);
    check_lookup("R7", 30'h40, 8'h01);

    // R3 / R4: fill past the end so the pointer wraps and overwrites
    for (int k = 0; k < DEPTH; k++)
      do_insert(30'h100 + 30'(k), 28'h1000 + 28'(k), 8'h02, 0, 4'(k), 4'(k + 1), k[0], k[1]);
    check_lookup("R3", 30'h40, 8'h01);
    for (int k = 0; k < DEPTH; k++) check_lookup("R3", 30'h100 + 30'(k), 8'h02);
    check_peek("R4", 0);
    do_insert(30'h200, 28'h2000, 8'h02, 0, 4'h9, 4'h9, 1, 1);
    check_lookup("R4", 30'h200, 8'h02);
    check_peek("R4", 0);

    // R5: flush-all
    flush_everything();
    check_lookup("R5", 30'h200, 8'h02);
    check_lookup("R5", 30'h101, 8'h02);
    check_peek("R5", 0);

    @(negedge clk); @(negedge clk);
    finish_run();
  end
endmodule